// File: doc/BRIEF.md
# Power-to-Frequency Pulse Converter

This block turns a stream of signed, already filtered real-power samples into pulse trains whose rate follows the accumulated energy. Every sample that arrives with its valid strobe adds its magnitude to two accumulators. Each accumulator has a power-of-two threshold. When an accumulator reaches its threshold, the threshold is subtracted and one pulse is requested. Any energy left over stays in the accumulator for the next pulse.

The slow energy train has a high threshold, so each of its pulses averages power over a long interval. Its pulses go out active low and take turns between two outputs. A two-bit rate select sets the slow threshold, so a full-scale input gives a full-scale rate equal to the clock divided by a power of two. The calibration train shares the same samples but has a much lower threshold. A boost input sets that threshold. Because the calibration threshold does not follow the rate select, its multiple of the slow rate grows as the selected slow rate falls, up to 128 times. A flag reports whether the most recent sample was negative, meaning energy flowing in reverse.

Top module: `pwr_pulse_gen`

## Requirements
- R1: A synchronous reset clears both accumulators and the pending-pulse counts, drives `slow_a_n`, `slow_b_n` and `cal_n` high, and clears `reverse`.
- R2: The slow threshold is 2^(PW-1+BASE_SHIFT-rate_sel), where `rate_sel` is read as an unsigned value 0 to 3. A full-scale sample on every clock therefore gives a slow full-scale rate of the clock divided by 2^(BASE_SHIFT-rate_sel).
- R3: When a valid sample brings an accumulator to a value greater than or equal to its threshold, one pulse is requested and the threshold is subtracted. The remainder is kept.
- R4: The calibration threshold is 2^(PW-1+BASE_SHIFT-7) when `cal_boost` is 1 and 2^(PW-1+BASE_SHIFT-6) when it is 0. The calibration rate is therefore 2^(7-rate_sel) or 2^(6-rate_sel) times the slow rate.
- R5: A negative sample (two's complement, sign in bit PW-1) adds its magnitude to both accumulators. After each valid sample, `reverse` shows that sample's sign bit.
- R6: While `smp_valid` is 0, `smp_data` has no effect on the accumulators, on the pulses or on `reverse`.
- R7: Slow pulses alternate between outputs, with `slow_a_n` first after reset and then `slow_b_n`. The two slow outputs are never low together.
- R8: Each slow pulse is low for exactly SLOW_W cycles and each calibration pulse for exactly CAL_W cycles. Within each train, successive pulses start at least twice the pulse width apart. Requests that come in sooner wait in a queue of up to 2^PEND_W-1 entries per train and are issued in order.
- R9: A change of `rate_sel` or `cal_boost` applies to the threshold of the next valid sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_valid | input | 1 | Qualifies `smp_data` for one cycle |
| smp_data | input | PW | Signed filtered power sample |
| rate_sel | input | 2 | Slow full-scale rate select |
| cal_boost | input | 1 | Selects the larger calibration multiple |
| slow_a_n | output | 1 | Slow energy pulse, first output, active low |
| slow_b_n | output | 1 | Slow energy pulse, second output, active low |
| cal_n | output | 1 | Calibration pulse, active low |
| reverse | output | 1 | Sign of the most recent valid sample |

## Verification
If an accumulator is wrong, for example because a remainder is dropped, a threshold is off by one shift, or a negative sample is subtracted instead of added, the design gives too many or too few pulses. The scoreboard catches this either as an unexpected falling edge or as an expected pulse still waiting when the run drains, no later than a few thresholds' worth of samples. If the queue or the shaping counters are wrong, the pulse widths, the spacing between pulses or the A/B order change within the same pulse. A stale sign shows up on `reverse` in the cycle after the sample.

// File: rtl/pwr_pulse_gen.sv
module pwr_pulse_gen #(
  parameter int PW         = 16,
  parameter int BASE_SHIFT = 22,
  parameter int SLOW_W     = 16,
  parameter int CAL_W      = 4,
  parameter int PEND_W     = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          smp_valid,
  input  logic [PW-1:0] smp_data,
  input  logic [1:0]    rate_sel,
  input  logic          cal_boost,
  output logic          slow_a_n,
  output logic          slow_b_n,
  output logic          cal_n,
  output logic          reverse
);
  localparam int ACC_W  = PW + BASE_SHIFT + 1;
  localparam int FS_LOG = PW - 1 + BASE_SHIFT;
  localparam int SCW    = $clog2(2*SLOW_W + 1);
  localparam int CCW    = $clog2(2*CAL_W + 1);
  localparam logic [ACC_W-1:0]  ONE      = ACC_W'(1);
  localparam logic [SCW-1:0]    S_FULL   = SCW'(2*SLOW_W);
  localparam logic [SCW-1:0]    S_HALF   = SCW'(SLOW_W);
  localparam logic [CCW-1:0]    C_FULL   = CCW'(2*CAL_W);
  localparam logic [CCW-1:0]    C_HALF   = CCW'(CAL_W);
  localparam logic [PEND_W-1:0] PEND_MAX = '1;

  logic [PW-1:0]     mag;
  logic [ACC_W-1:0]  slow_acc, cal_acc, slow_sum, cal_sum, slow_thr, cal_thr;
  logic              slow_hit, cal_hit, slow_start, cal_start, cur_b;
  logic [SCW-1:0]    slow_cnt;
  logic [CCW-1:0]    cal_cnt;
  logic [PEND_W-1:0] slow_pend, cal_pend;

  assign mag      = smp_data[PW-1] ? (~smp_data + 1'b1) : smp_data;
  assign slow_thr = ONE << (FS_LOG - int'(rate_sel));
  assign cal_thr  = ONE << (FS_LOG - (cal_boost ? 7 : 6));
  assign slow_sum = slow_acc + ACC_W'(mag);
  assign cal_sum  = cal_acc + ACC_W'(mag);
  assign slow_hit = smp_valid && (slow_sum >= slow_thr);
  assign cal_hit  = smp_valid && (cal_sum >= cal_thr);

  always_ff @(posedge clk) begin
    if (rst) begin
      slow_acc <= '0;
      cal_acc  <= '0;
      reverse  <= 1'b0;
    end else if (smp_valid) begin
      slow_acc <= slow_hit ? slow_sum - slow_thr : slow_sum;
      cal_acc  <= cal_hit ? cal_sum - cal_thr : cal_sum;
      reverse  <= smp_data[PW-1];
    end
  end

  assign slow_start = (slow_cnt <= SCW'(1)) && (slow_pend != '0);
  assign cal_start  = (cal_cnt <= CCW'(1)) && (cal_pend != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      slow_cnt  <= '0;
      slow_pend <= '0;
      cur_b     <= 1'b1;
    end else begin
      if (slow_start) begin
        slow_cnt <= S_FULL;
        cur_b    <= ~cur_b;
      end else if (slow_cnt != '0) begin
        slow_cnt <= slow_cnt - 1'b1;
      end
      if (slow_hit && !slow_start && slow_pend != PEND_MAX)
        slow_pend <= slow_pend + 1'b1;
      else if (!slow_hit && slow_start)
        slow_pend <= slow_pend - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cal_cnt  <= '0;
      cal_pend <= '0;
    end else begin
      if (cal_start)
        cal_cnt <= C_FULL;
      else if (cal_cnt != '0)
        cal_cnt <= cal_cnt - 1'b1;
      if (cal_hit && !cal_start && cal_pend != PEND_MAX)
        cal_pend <= cal_pend + 1'b1;
      else if (!cal_hit && cal_start)
        cal_pend <= cal_pend - 1'b1;
    end
  end

  assign slow_a_n = !((slow_cnt > S_HALF) && !cur_b);
  assign slow_b_n = !((slow_cnt > S_HALF) && cur_b);
  assign cal_n    = !(cal_cnt > C_HALF);
endmodule

// File: rtl/pwr_pulse_gen_chk.sv
module pwr_pulse_gen_chk #(
  parameter int SLOW_W = 16,
  parameter int CAL_W  = 4
) (
  input logic clk,
  input logic rst,
  input logic smp_valid,
  input logic smp_sign,
  input logic slow_a_n,
  input logic slow_b_n,
  input logic cal_n,
  input logic reverse
);
  logic        slow_low;
  logic [15:0] slow_lcnt, cal_lcnt, cal_hcnt;

  assign slow_low = !(slow_a_n && slow_b_n);

  always_ff @(posedge clk) begin
    if (rst) begin
      slow_lcnt <= '0;
      cal_lcnt  <= '0;
      cal_hcnt  <= '1;
    end else begin
      slow_lcnt <= slow_low ? slow_lcnt + 1'b1 : '0;
      cal_lcnt  <= !cal_n ? cal_lcnt + 1'b1 : '0;
      if (!cal_n) cal_hcnt <= '0;
      else if (cal_hcnt != '1) cal_hcnt <= cal_hcnt + 1'b1;
    end
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> (slow_a_n && slow_b_n && cal_n && !reverse));

  // R7
  slow_mutex_chk: assert property (@(posedge clk) disable iff (rst)
    (slow_a_n || slow_b_n));

  // R8
  slow_width_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(slow_low) |-> (slow_lcnt == 16'(SLOW_W)));

  // R8
  cal_width_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(cal_n) |-> (cal_lcnt == 16'(CAL_W)));

  // R8
  cal_gap_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(cal_n) |-> (cal_hcnt >= 16'(CAL_W)));

  // R5
  reverse_sign_chk: assert property (@(posedge clk) disable iff (rst)
    smp_valid |=> (reverse == $past(smp_sign)));

  // R6
  reverse_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !smp_valid |=> $stable(reverse));
endmodule

bind pwr_pulse_gen pwr_pulse_gen_chk #(.SLOW_W(SLOW_W), .CAL_W(CAL_W)) i_chk (
  .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_sign(smp_data[PW-1]),
  .slow_a_n(slow_a_n), .slow_b_n(slow_b_n), .cal_n(cal_n), .reverse(reverse)
);

// File: tb/test_pwr_pulse_gen.sv
module test_pwr_pulse_gen;
  localparam int PW = 8, BS = 7, SW = 16, CW = 4;

  logic clk = 1'b0, rst = 1'b1, smp_valid = 1'b0, cal_boost = 1'b1;
  logic [PW-1:0] smp_data = '0;
  logic [1:0] rate_sel = 2'd0;
  logic slow_a_n, slow_b_n, cal_n, reverse;

  pwr_pulse_gen #(.PW(PW), .BASE_SHIFT(BS), .SLOW_W(SW), .CAL_W(CW), .PEND_W(4)) i_pwr_pulse_gen (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
    .rate_sel(rate_sel), .cal_boost(cal_boost), .slow_a_n(slow_a_n),
    .slow_b_n(slow_b_n), .cal_n(cal_n), .reverse(reverse));

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0, mon_on = 0;
  int slow_q[$];
  int cal_q[$];
  longint m_slow = 0, m_cal = 0;
  int next_b = 0;
  int falls = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // R2 / R4 thresholds written from the requirement formulas
  function automatic longint slow_thr(input int sel);
    return longint'(1) << (PW - 1 + BS - sel);
  endfunction
  function automatic longint cal_thr(input bit boost);
    return longint'(1) << (PW - 1 + BS - (boost ? 7 : 6));
  endfunction

  task automatic send(input int s);
    longint m;
    m = (s < 0) ? -s : s;
    @(negedge clk);
    smp_valid = 1'b1;
    smp_data = PW'(s);
    // R3 / R9: threshold taken from the selects present at this sample
    m_slow += m;
    if (m_slow >= slow_thr(rate_sel)) begin
      m_slow -= slow_thr(rate_sel);
      slow_q.push_back(next_b);
      next_b ^= 1;
    end
    m_cal += m;
    if (m_cal >= cal_thr(cal_boost)) begin
      m_cal -= cal_thr(cal_boost);
      cal_q.push_back(1);
    end
    @(negedge clk);
    smp_valid = 1'b0;
    smp_data = PW'(-37);
    chk(reverse == (s < 0), "R5 reverse flag", reverse, s < 0);
    repeat (8) @(negedge clk);
  endtask

  // monitor: pops expected pulses as falling edges appear
  bit pa = 1, pb = 1, pc = 1;
  int cyc = 0, slow_low = 0, cal_low = 0, last_slow = -1000, last_cal = -1000;
  always @(negedge clk) begin
    cyc++;
    if (mon_on && !rst) begin
      if (!slow_a_n && !slow_b_n) chk(0, "R7 both slow outputs low", 0, 1);
      if ((pa && !slow_a_n) || (pb && !slow_b_n)) begin
        falls++;
        chk(cyc - last_slow >= 2*SW, "R8 slow spacing", cyc - last_slow, 2*SW);
        last_slow = cyc;
        if (slow_q.size() == 0) chk(0, "R3 unexpected slow pulse", 1, 0);
        else begin
          int e;
          e = slow_q.pop_front();
          chk(e == (!slow_b_n ? 1 : 0), "R7 slow output order", !slow_b_n, e);
        end
      end
      if (pc && !cal_n) begin
        falls++;
        chk(cyc - last_cal >= 2*CW, "R8 cal spacing", cyc - last_cal, 2*CW);
        last_cal = cyc;
        if (cal_q.size() == 0) chk(0, "R4 unexpected cal pulse", 1, 0);
        else void'(cal_q.pop_front());
      end
      if (!(slow_a_n && slow_b_n)) slow_low++;
      else if (slow_low != 0) begin
        chk(slow_low == SW, "R8 slow width", slow_low, SW);
        slow_low = 0;
      end
      if (!cal_n) cal_low++;
      else if (cal_low != 0) begin
        chk(cal_low == CW, "R8 cal width", cal_low, CW);
        cal_low = 0;
      end
    end
    pa = slow_a_n; pb = slow_b_n; pc = cal_n;
  end

  task automatic drain(input string req);
    repeat (800) @(negedge clk);
    chk(slow_q.size() == 0, {req, " slow pulses missing"}, slow_q.size(), 0);
    chk(cal_q.size() == 0, {req, " cal pulses missing"}, cal_q.size(), 0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    // R1
    chk(slow_a_n && slow_b_n && cal_n, "R1 outputs idle in reset", {slow_a_n, slow_b_n, cal_n}, 3'b111);
    chk(!reverse, "R1 reverse cleared", reverse, 0);
    m_slow = 0; m_cal = 0; next_b = 0;
    slow_q.delete(); cal_q.delete();
    rst = 1'b0;
    mon_on = 1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    do_reset();
    // R2 / R4: slowest rate, boosted calibration, positive dc
    rate_sel = 2'd0; cal_boost = 1'b1;
    for (int i = 0; i < 300; i++) send(100);
    // R5 / R9: switch to fastest rate, normal calibration, reverse energy
    rate_sel = 2'd3; cal_boost = 1'b0;
    for (int i = 0; i < 200; i++) send(-90);
    drain("R9");
    // alternating full-scale pattern at the middle rates
    rate_sel = 2'd1; cal_boost = 1'b1;
    for (int i = 0; i < 150; i++) send((i % 2) ? -128 : 127);
    rate_sel = 2'd2; cal_boost = 1'b0;
    for (int i = 0; i < 150; i++) send((i % 3 == 0) ? -60 : 113);
    drain("R2");
    // R6: data without valid must not produce pulses or touch the flag
    begin
      int f0;
      bit r0;
      f0 = falls; r0 = reverse;
      @(negedge clk);
      for (int i = 0; i < 400; i++) begin
        smp_data = PW'(i % 2 ? -128 : 127);
        @(negedge clk);
      end
      chk(falls == f0, "R6 pulses while valid low", falls - f0, 0);
      chk(reverse == r0, "R6 reverse while valid low", reverse, r0);
    end
    // R1 / R3: reset clears residue; exact threshold boundary
    do_reset();
    rate_sel = 2'd3; cal_boost = 1'b1;
    send(64);
    send(-64);
    repeat (20) @(negedge clk);
    chk(cal_q.size() == 0 && falls > 0, "R3 equal-to-threshold pulse", cal_q.size(), 0);
    for (int i = 0; i < 32; i++) send(64);
    drain("R3");
    finish_run();
  end
endmodule